// File: doc/BRIEF.md
# Interrupt Priority and Entry Sequencer

This block decides which pending interrupt an 8-bit processor takes next and then carries out the entry sequence for it on a small memory bus. The datapath pulses `start` between instructions and hands over its program counter, status flags and stack pointer. The sequencer chooses among three requests, highest first: a latched reset request, a non-maskable request that is latched on its rising edge, and a maskable request. The maskable request is the OR of a video interrupt line and a timer interrupt line.

For a non-maskable or maskable entry, the block pushes the return address (high byte, then low byte) and a status byte onto the page-1 stack. It then sets the interrupt-disable flag, reads the little-endian vector and returns the new program counter. A reset entry pushes nothing. It clears the pending requests, pulses a clear strobe for the processor port and loads the program counter from the reset vector.

The memory bus never stalls and has no back-pressure. A write completes in the cycle `mem_we` is high. Read data must be on `mem_rdata` in the cycle after `mem_re`. The control pins `start`, `busy` and `done` are plain levels and pulses, not a handshake.

Top module: `irq_entry_seq`

## Requirements
- R1: The choice made at a `start` follows the fixed order reset, then non-maskable, then maskable. The maskable request is `irq_video | irq_timer`, and it is taken only when bit 2 (I) of `flags_in` is 0. `kind_out` reports the choice as 0 none, 1 maskable, 2 non-maskable, 3 reset.
- R2: The non-maskable request is latched only on a 0-to-1 change of `nmi_in` seen at a clock edge before the `start`. Taking it, or taking a reset, clears the latch. A line held high does not raise a second request.
- R3: A maskable or non-maskable entry writes three bytes, in bus cycles 2, 3 and 4 after the `start` edge:
  - `pc_in[15:8]` to `16'h0100 | sp`;
  - `pc_in[7:0]` to `16'h0100 | (sp-1)`;
  - the status byte to `16'h0100 | (sp-2)`.
  The status byte is, from bit 7 down, N=`flags_in[7]`, V=`flags_in[6]`, 1, 0, D=`flags_in[3]`, I=`flags_in[2]`, Z=`flags_in[1]`, C=`flags_in[0]`.
- R4: Each push decrements the stack pointer modulo 256. After a maskable or non-maskable entry, `sp_out` is `sp_in - 3` (mod 256). After a reset entry, `sp_out` is `sp_in`.
- R5: The vector is read as two bytes, the low byte at the vector address and the high byte at the vector address plus 1, and `pc_out` becomes `{high, low}`. The vector address is 16'hFFFA for non-maskable, 16'hFFFC for reset and 16'hFFFE for maskable.
- R6: A maskable or non-maskable entry keeps `busy` high for 7 cycles. `done` is a single-cycle pulse in the cycle after the last busy cycle, with `pc_out` valid.
- R7: A reset entry performs no write and keeps `busy` high for 4 cycles, with `done` in the fifth. It pulses `port_clr` for exactly one cycle.
- R8: After any taken entry, `flags_out` equals `flags_in` with bit 2 set. After a `start` with nothing eligible, `flags_out` equals `flags_in`.
- R9: A `start` with nothing eligible makes no bus access. It keeps `busy` high for 1 cycle, pulses `done` in the second cycle, and sets `pc_out` to `pc_in`.
- R10: A `start` that arrives while `busy` is high is ignored.
- R11: After reset:
  - `busy`, `done`, `mem_we`, `mem_re` and `port_clr` are 0;
  - `pc_out` and `flags_out` are 0;
  - `sp_out` is 8'hFF;
  - `kind_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_req | input | 1 | Reset request, latched while high |
| nmi_in | input | 1 | Non-maskable request line, rising edge latched |
| irq_video | input | 1 | Video maskable source, level |
| irq_timer | input | 1 | Timer maskable source, level |
| start | input | 1 | Strobe to evaluate and take an interrupt |
| pc_in | input | 16 | Current program counter |
| flags_in | input | 8 | Current status flags, NV-BDIZC layout |
| sp_in | input | 8 | Current stack pointer |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle completion pulse |
| kind_out | output | 2 | Entry taken: 0 none, 1 maskable, 2 non-maskable, 3 reset |
| pc_out | output | 16 | New program counter |
| sp_out | output | 8 | New stack pointer |
| flags_out | output | 8 | New status flags |
| port_clr | output | 1 | Pulse clearing the processor port on reset entry |
| mem_addr | output | 16 | Bus address |
| mem_we | output | 1 | Bus write strobe |
| mem_wdata | output | 8 | Bus write data |
| mem_re | output | 1 | Bus read strobe |
| mem_rdata | input | 8 | Bus read data, valid the cycle after `mem_re` |

## Verification
Counting from the edge that samples `start`:
- For a maskable or non-maskable entry, the stack writes fall in cycles 2 to 4, the vector reads in cycles 5 and 6, and `done` with the new `pc_out`, `sp_out` and `flags_out` in cycle 8.
- For a reset entry, `done` falls in cycle 5.
- With nothing eligible, `done` falls in cycle 2.

The bench samples every output on the falling edge of each cycle from cycle 1 onward. It records each write and read with the cycle in which it appeared, and compares the cycle numbers, addresses, data and the count of `busy` cycles against values it works out from `pc_in`, `sp_in`, `flags_in` and the vector bytes its bus model returns. The requests are applied at least one edge before `start`. The full 32-case priority matrix is run, and maskable entries are swept over 128 flag patterns and stack pointers near the wrap point.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_IRQ  = 2'd1,
    K_NMI  = 2'd2,
    K_RST  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARB,
    S_PUSH_HI,
    S_PUSH_LO,
    S_PUSH_ST,
    S_VEC_LO,
    S_VEC_HI,
    S_FIN
  } seq_state_e;

  localparam int I_BIT     = 2;
  localparam int B_BIT     = 4;
  localparam int ONE_BIT   = 5;

  // Stack image of the flags: fixed one in bit 5, break bit cleared.
  function automatic logic [7:0] stack_status(input logic [7:0] fl);
    logic [7:0] s;
    s = fl;
    s[ONE_BIT] = 1'b1;
    s[B_BIT]   = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic reset_req,
  input  logic clr_nmi,
  input  logic clr_rst,
  output logic nmi_pend,
  output logic rst_pend
);
  logic nmi_prev;
  logic nmi_edge;

  assign nmi_edge = nmi_in & ~nmi_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
      rst_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      if (nmi_edge)     nmi_pend <= 1'b1;
      else if (clr_nmi) nmi_pend <= 1'b0;
      if (reset_req)    rst_pend <= 1'b1;
      else if (clr_rst) rst_pend <= 1'b0;
    end
  end

  // R2: a fresh rising edge is always captured
  a_r2_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_in && !nmi_prev) |=> nmi_pend);

  // R2: without an edge the latch never sets by itself
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_pend && !(nmi_in && !nmi_prev)) |=> !nmi_pend);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
#(
  parameter int NUM_IRQ = 2
) (
  input  logic               rst_pend,
  input  logic               nmi_pend,
  input  logic [NUM_IRQ-1:0] irq_src,
  input  logic               i_mask,
  output kind_e              kind
);
  logic irq_any;

  assign irq_any = |irq_src;

  always_comb begin
    if (rst_pend)                kind = K_RST;
    else if (nmi_pend)           kind = K_NMI;
    else if (irq_any && !i_mask) kind = K_IRQ;
    else                         kind = K_NONE;
  end

  // R1: a maskable entry is never chosen while masked
  always_comb begin
    if (kind == K_IRQ) a_r1_irq_unmasked: assert (i_mask == 1'b0);
  end

endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel
  import irq_seq_pkg::*;
#(
  parameter int          PC_W    = 16,
  parameter logic [15:0] VEC_NMI = 16'hFFFA,
  parameter logic [15:0] VEC_RST = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ = 16'hFFFE
) (
  input  kind_e           kind,
  output logic [PC_W-1:0] vec_addr
);
  always_comb begin
    case (kind)
      K_NMI:   vec_addr = PC_W'(VEC_NMI);
      K_RST:   vec_addr = PC_W'(VEC_RST);
      default: vec_addr = PC_W'(VEC_IRQ);
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int         PC_W       = 16,
  parameter int         D_W        = 8,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reset_req,
  input  logic            nmi_in,
  input  logic            irq_video,
  input  logic            irq_timer,
  input  logic            start,
  input  logic [PC_W-1:0] pc_in,
  input  logic [D_W-1:0]  flags_in,
  input  logic [D_W-1:0]  sp_in,
  output logic            busy,
  output logic            done,
  output logic [1:0]      kind_out,
  output logic [PC_W-1:0] pc_out,
  output logic [D_W-1:0]  sp_out,
  output logic [D_W-1:0]  flags_out,
  output logic            port_clr,
  output logic [PC_W-1:0] mem_addr,
  output logic            mem_we,
  output logic [D_W-1:0]  mem_wdata,
  output logic            mem_re,
  input  logic [D_W-1:0]  mem_rdata
);
  localparam int          HI_W   = PC_W - D_W;
  localparam logic [D_W-1:0] SP_INIT = '1;

  seq_state_e     st;
  kind_e          kind_q, sel_kind;
  logic [PC_W-1:0] pc_q, pc_res_q, vec_addr;
  logic [D_W-1:0]  fl_q, sp_q, lo_q;
  logic            done_q;
  logic            nmi_pend, rst_pend;
  logic            accept, clr_nmi, clr_rst, pushing;

  assign accept  = (st == S_IDLE) && start;
  assign clr_nmi = accept && (sel_kind == K_NMI || sel_kind == K_RST);
  assign clr_rst = accept && (sel_kind == K_RST);

  irq_req_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_in    (nmi_in),
    .reset_req (reset_req),
    .clr_nmi   (clr_nmi),
    .clr_rst   (clr_rst),
    .nmi_pend  (nmi_pend),
    .rst_pend  (rst_pend)
  );

  irq_arbiter #(.NUM_IRQ(2)) u_arb (
    .rst_pend (rst_pend),
    .nmi_pend (nmi_pend),
    .irq_src  ({irq_timer, irq_video}),
    .i_mask   (flags_in[I_BIT]),
    .kind     (sel_kind)
  );

  irq_vector_sel #(.PC_W(PC_W)) u_vec (
    .kind     (kind_q),
    .vec_addr (vec_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind_q   <= K_NONE;
      pc_q     <= '0;
      pc_res_q <= '0;
      fl_q     <= '0;
      sp_q     <= SP_INIT;
      lo_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pc_q   <= pc_in;
          fl_q   <= flags_in;
          sp_q   <= sp_in;
          kind_q <= sel_kind;
          st     <= S_ARB;
        end
        S_ARB: begin
          case (kind_q)
            K_NONE: begin
              pc_res_q <= pc_q;
              done_q   <= 1'b1;
              st       <= S_IDLE;
            end
            K_RST: begin
              fl_q[I_BIT] <= 1'b1;
              st          <= S_VEC_LO;
            end
            default: st <= S_PUSH_HI;
          endcase
        end
        S_PUSH_HI: begin
          sp_q <= sp_q - 1'b1;
          st   <= S_PUSH_LO;
        end
        S_PUSH_LO: begin
          sp_q <= sp_q - 1'b1;
          st   <= S_PUSH_ST;
        end
        S_PUSH_ST: begin
          sp_q        <= sp_q - 1'b1;
          fl_q[I_BIT] <= 1'b1;
          st          <= S_VEC_LO;
        end
        S_VEC_LO: st <= S_VEC_HI;
        S_VEC_HI: begin
          lo_q <= mem_rdata;
          st   <= S_FIN;
        end
        S_FIN: begin
          pc_res_q <= {mem_rdata[HI_W-1:0], lo_q};
          done_q   <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pushing = (st == S_PUSH_HI) || (st == S_PUSH_LO) || (st == S_PUSH_ST);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    if (pushing) mem_addr = {STACK_PAGE, sp_q};
    else if (st == S_VEC_LO) mem_addr = vec_addr;
    else if (st == S_VEC_HI) mem_addr = vec_addr + 1'b1;
    case (st)
      S_PUSH_HI: mem_wdata = pc_q[PC_W-1:D_W];
      S_PUSH_LO: mem_wdata = pc_q[D_W-1:0];
      S_PUSH_ST: mem_wdata = stack_status(fl_q);
      default:   mem_wdata = '0;
    endcase
  end

  assign mem_we    = pushing;
  assign mem_re    = (st == S_VEC_LO) || (st == S_VEC_HI);
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign kind_out  = kind_q;
  assign pc_out    = pc_res_q;
  assign sp_out    = sp_q;
  assign flags_out = fl_q;
  assign port_clr  = (st == S_ARB) && (kind_q == K_RST);

  // R4: every push is followed by a one-step decrement of the stack pointer
  a_r4_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_q == $past(sp_q) - 1'b1));

  // R6: done lasts one cycle and only outside a sequence
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5: reads and writes never share a cycle
  a_r5_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R7: a reset entry never writes the stack
  a_r7_reset_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == K_RST) |-> !mem_we);

  // R10: state stays put across a start seen while busy, apart from sequencing
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(pc_q));

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 0, nmi_in = 0, irq_video = 0, irq_timer = 0, start = 0;
  logic [15:0] pc_in = 0;
  logic [7:0]  flags_in = 0, sp_in = 0;
  logic        busy, done, port_clr, mem_we, mem_re;
  logic [1:0]  kind_out;
  logic [15:0] pc_out, mem_addr;
  logic [7:0]  sp_out, flags_out, mem_wdata;
  logic [7:0]  mem_rdata = 0;
  logic [7:0]  seed = 8'h3C;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_in(nmi_in),
    .irq_video(irq_video), .irq_timer(irq_timer), .start(start),
    .pc_in(pc_in), .flags_in(flags_in), .sp_in(sp_in),
    .busy(busy), .done(done), .kind_out(kind_out), .pc_out(pc_out),
    .sp_out(sp_out), .flags_out(flags_out), .port_clr(port_clr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] vb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ seed;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= vb(mem_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_req(input bit r, input bit n);
    @(negedge clk); reset_req = r; nmi_in = n;
    @(negedge clk); reset_req = 0; nmi_in = 0;
  endtask

  // Runs one start and checks all results. poke: cycle at which start is re-raised (0 = never).
  task automatic run_check(input int ek, input int poke);
    int busy_n, done_c, nw, nr, pclr, first_w, first_r;
    logic [15:0] wa[4]; logic [7:0] wd[4]; logic [15:0] ra[4];
    logic [15:0] vec, exp_pc;
    logic [7:0]  st_b;
    bit got;
    busy_n = 0; done_c = 0; nw = 0; nr = 0; pclr = 0; got = 0;
    first_w = 0; first_r = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int c = 1; c <= 40 && !got; c++) begin
      if (done) begin got = 1; done_c = c; end
      if (busy) busy_n++;
      if (port_clr) pclr++;
      if (mem_we) begin
        if (nw == 0) first_w = c;
        if (nw < 4) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
        nw++;
      end
      if (mem_re) begin
        if (nr == 0) first_r = c;
        if (nr < 4) ra[nr] = mem_addr;
        nr++;
      end
      if (!got) begin
        start = (c == poke);
        @(negedge clk);
      end
    end
    start = 0;
    chk(got, "R6", "done seen", got, 1);
    chk(kind_out == 2'(ek), "R1", "kind", kind_out, ek);
    vec = (ek == 2) ? 16'hFFFA : (ek == 3) ? 16'hFFFC : 16'hFFFE;
    exp_pc = {vb(vec + 16'd1), vb(vec)};
    if (ek == 1 || ek == 2) begin
      st_b = {flags_in[7:6], 2'b10, flags_in[3:0]};
      chk(busy_n == 7, "R6", "busy cycles", busy_n, 7);
      chk(done_c == 8, "R6", "done cycle", done_c, 8);
      chk(nw == 3 && first_w == 2, "R3", "write count/cycle", nw*100+first_w, 302);
      if (nw == 3) begin
        chk(wa[0] == {8'h01, sp_in}, "R3", "push hi addr", wa[0], {8'h01, sp_in});
        chk(wa[1] == {8'h01, sp_in - 8'd1}, "R4", "push lo addr", wa[1], {8'h01, sp_in - 8'd1});
        chk(wa[2] == {8'h01, sp_in - 8'd2}, "R4", "push st addr", wa[2], {8'h01, sp_in - 8'd2});
        chk(wd[0] == pc_in[15:8], "R3", "push hi data", wd[0], pc_in[15:8]);
        chk(wd[1] == pc_in[7:0], "R3", "push lo data", wd[1], pc_in[7:0]);
        chk(wd[2] == st_b, "R3", "status byte", wd[2], st_b);
      end
      chk(sp_out == sp_in - 8'd3, "R4", "sp_out", sp_out, sp_in - 8'd3);
      chk(nr == 2 && first_r == 5, "R5", "read count/cycle", nr*100+first_r, 205);
    end else if (ek == 3) begin
      chk(busy_n == 4 && done_c == 5, "R7", "reset timing", busy_n*100+done_c, 405);
      chk(nw == 0, "R7", "reset writes", nw, 0);
      chk(pclr == 1, "R7", "port_clr pulses", pclr, 1);
      chk(sp_out == sp_in, "R4", "sp kept on reset", sp_out, sp_in);
      chk(nr == 2 && first_r == 2, "R5", "reset read count/cycle", nr*100+first_r, 202);
    end else begin
      chk(busy_n == 1 && done_c == 2, "R9", "none timing", busy_n*100+done_c, 102);
      chk(nw + nr == 0, "R9", "none bus traffic", nw + nr, 0);
      chk(pc_out == pc_in, "R9", "none pc", pc_out, pc_in);
      chk(flags_out == flags_in, "R8", "none flags", flags_out, flags_in);
    end
    if (ek != 0) begin
      if (nr == 2) begin
        chk(ra[0] == vec, "R5", "vector lo addr", ra[0], vec);
        chk(ra[1] == vec + 16'd1, "R5", "vector hi addr", ra[1], vec + 16'd1);
      end
      chk(pc_out == exp_pc, "R5", "pc_out", pc_out, exp_pc);
      chk(flags_out == (flags_in | 8'h04), "R8", "flags_out I set", flags_out, flags_in | 8'h04);
    end
    if (ek != 3) chk(pclr == 0, "R7", "no port_clr", pclr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !mem_we && !mem_re && !port_clr, "R11", "idle strobes",
        {busy, done, mem_we, mem_re, port_clr}, 0);
    chk(pc_out == 0 && flags_out == 0, "R11", "pc/flags zero", {pc_out, flags_out}, 0);
    chk(sp_out == 8'hFF && kind_out == 0, "R11", "sp/kind", {sp_out, 6'd0, kind_out}, 16'hFF00);

    // R1 priority matrix, all 32 combinations
    for (int m = 0; m < 32; m++) begin
      int ek;
      pc_in = 16'h1234 + 16'(m * 97); sp_in = 8'(8'hF0 + m); seed = 8'(m * 13);
      flags_in = m[4] ? 8'hC4 : 8'h4B;
      irq_video = m[2]; irq_timer = m[3];
      pulse_req(m[0], m[1]);
      ek = m[0] ? 3 : m[1] ? 2 : ((m[2] | m[3]) && !m[4]) ? 1 : 0;
      run_check(ek, 0);
      irq_video = 0; irq_timer = 0;
    end

    // R3 R4 sweep: maskable entries over flag patterns and stack pointers near wrap
    for (int s = 0; s < 6; s++) begin
      for (int f = 0; f < 256; f++) begin
        if (f[2]) continue;
        flags_in = 8'(f);
        sp_in = (s == 4) ? 8'h80 : (s == 5) ? 8'hFF : 8'(s);
        pc_in = {8'(f), 8'(f ^ 8'hA5)};
        seed = 8'(f + s);
        irq_video = f[0]; irq_timer = ~f[0];
        run_check(1, 0);
      end
    end
    irq_video = 0; irq_timer = 0;

    // R2 held line does not retrigger; new edge does
    flags_in = 8'h00; sp_in = 8'h10; pc_in = 16'hBEEF;
    @(negedge clk); nmi_in = 1;
    @(negedge clk);
    run_check(2, 0);
    run_check(0, 0);
    @(negedge clk); nmi_in = 0;
    @(negedge clk); nmi_in = 1;
    @(negedge clk);
    run_check(2, 0);
    nmi_in = 0;

    // R2 reset clears a pending non-maskable request
    pulse_req(1, 1);
    run_check(3, 0);
    run_check(0, 0);

    // R10 start during busy ignored
    irq_timer = 1; flags_in = 8'h01; sp_in = 8'h01;
    run_check(1, 3);
    irq_timer = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy && !done, "R10", "no second sequence", {busy, done}, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule